// File: doc/BRIEF.md
# Interrupt Source Trigger Detector

This block turns a bank of raw interrupt lines into pending flags for a downstream arbiter. Every line first passes through a two-flop synchronizer. A per-source sense mode then decides how the synchronized level becomes a pending flag. In level mode the flag mirrors the line. In the three edge modes, a falling, rising or either transition sets a sticky flag that stays set until it is cleared.

Software reaches the block through a byte-wide register port. It can read any flag, clear an edge flag by writing zero, and reprogram the sense mode of a group of external pin sources. The arbiter drops the flag of the source it has just serviced by pulsing an acknowledge with that source's index. All sources other than the pin group keep the mode chosen at reset by a configuration mask.

Top module: `irq_trigger_bank`

## Requirements
- R1: Sense modes are encoded on two bits: 0 means level, 1 means falling edge, 2 means rising edge and 3 means both edges. Pin k (k < PIN_COUNT) controls source PIN_BASE+k through the register at address 0x100+k. Its mode is written from data bits [3:2] and reads back in bits [3:2], with all other bits reading as 0.
- R2: In level mode the pending flag equals the synchronized input, so it drops as soon as the synchronized input goes low.
- R3: In rising-edge mode a 0-to-1 transition of the synchronized input sets the flag.
- R4: In falling-edge mode a 1-to-0 transition of the synchronized input sets the flag, and a rising transition does not.
- R5: In both-edge mode either transition sets the flag.
- R6: In any edge mode a set flag stays set while no clear is requested, whatever the input does.
- R7: Writing 0x00 to flag address i (address bit 8 = 0, bits [7:0] = i) clears the flag of source i if that source is in an edge mode. A non-zero write to that address has no effect, and a write of zero to a level source has no effect.
- R8: A cycle with ack_valid high clears the flag of source ack_id if that source is in an edge mode. Level flags are not changed by an acknowledge.
- R9: After reset, all flags are 0 and the stored previous level is 0. Sources whose LEVEL_MASK bit is set start in level mode, and all others start in rising-edge mode.
- R10: A flag register reads as the flag in bit 0 with bits [7:1] at 0. Unmapped addresses read as 0x00.
- R11: When a trigger and a clear for the same edge source fall in the same cycle, the flag ends up set.
- R12: An input change reaches irq_pend on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt lines |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Register address: bit 8 = 0 selects flags, bit 8 = 1 selects pin control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ack_valid | input | 1 | Arbiter acknowledge strobe |
| ack_id | input | IDX_W | Index of the acknowledged source |
| irq_pend | output | NUM_SRC | Pending flags, one per source |

## Verification
Each of the four modes is driven with short level sequences through a pin source. A held-high run separates level tracking from sticky edge flags. A single transition in each direction shows which edges each mode accepts. A return to low shows whether a flag follows the line or latches. Directed cases then clear flags in four ways: a zero write, a non-zero write, an acknowledge, and a clear that coincides with a new trigger. Each clear is applied to both level and edge sources, which tells the ignore rules apart from the clear rules. A single-source timing probe pins the synchronizer latency to the exact edge.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'd0,
        SENSE_FALL  = 2'd1,
        SENSE_RISE  = 2'd2,
        SENSE_BOTH  = 2'd3
    } sense_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.s2;
endmodule

// File: rtl/trig_cell.sv
module trig_cell
    import trig_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl,
    input  sense_e mode,
    input  logic   clr_req,
    output logic   pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } cell_t;

    cell_t cell_d, cell_q;
    logic  hit;

    always_comb begin
        unique case (mode)
            SENSE_FALL: hit = cell_q.prev & ~lvl;
            SENSE_RISE: hit = ~cell_q.prev & lvl;
            SENSE_BOTH: hit = cell_q.prev ^ lvl;
            default:    hit = 1'b0;
        endcase
        cell_d      = cell_q;
        cell_d.prev = lvl;
        if (mode == SENSE_LEVEL)  cell_d.pend = lvl;
        else if (hit)             cell_d.pend = 1'b1;
        else if (clr_req)         cell_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign pend = cell_q.pend;

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LEVEL) |=> (pend == $past(lvl)));
    // R3
    rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_RISE && lvl && !cell_q.prev) |=> pend);
    // R4
    fall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_FALL && !lvl && cell_q.prev) |=> pend);
    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SENSE_LEVEL && pend && !clr_req) |=> pend);
    // R7
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SENSE_LEVEL && clr_req && lvl == cell_q.prev) |=> !pend);
endmodule

// File: rtl/irq_trigger_bank.sv
module irq_trigger_bank
    import trig_pkg::*;
#(
    parameter int NUM_SRC   = 256,
    parameter int PIN_BASE  = 64,
    parameter int PIN_COUNT = 16,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK =
        {{(NUM_SRC-80){1'b0}}, 16'hFFFF, 56'd0, 8'hFF},
    localparam int IDX_W = $clog2(NUM_SRC),
    localparam int PIN_W = $clog2(PIN_COUNT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_wen,
    input  logic [IDX_W:0]     reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_id,
    output logic [NUM_SRC-1:0] irq_pend
);
    typedef struct packed {
        logic [PIN_COUNT-1:0][1:0] pin_mode;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_SRC-1:0] lvl_s;
    logic [NUM_SRC-1:0] clr;
    sense_e             mode [NUM_SRC];
    logic [IDX_W-1:0]   idx;
    logic [PIN_W-1:0]   pin_sel;
    logic               pin_space, pin_hit, sw_clr;

    assign idx       = reg_addr[IDX_W-1:0];
    assign pin_sel   = reg_addr[PIN_W-1:0];
    assign pin_space = reg_addr[IDX_W];
    assign pin_hit   = pin_space && (idx < IDX_W'(PIN_COUNT));
    assign sw_clr    = reg_wen && !pin_space && (reg_wdata == 8'h00);

    trig_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (lvl_s)
    );

    always_comb begin
        regs_d = regs_q;
        if (reg_wen && pin_hit) regs_d.pin_mode[pin_sel] = reg_wdata[3:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < PIN_COUNT; k++)
                regs_q.pin_mode[k] <= LEVEL_MASK[PIN_BASE+k] ? 2'd0 : 2'd2;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i >= PIN_BASE && i < PIN_BASE + PIN_COUNT) begin : g_pin
            assign mode[i] = sense_e'(regs_q.pin_mode[i-PIN_BASE]);
        end else begin : g_fixed
            assign mode[i] = LEVEL_MASK[i] ? SENSE_LEVEL : SENSE_RISE;
        end
        assign clr[i] = (sw_clr && idx == IDX_W'(i)) ||
                        (ack_valid && ack_id == IDX_W'(i));
        trig_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (lvl_s[i]),
            .mode   (mode[i]),
            .clr_req(clr[i]),
            .pend   (irq_pend[i])
        );
    end

    always_comb begin
        if (!pin_space)   reg_rdata = {7'd0, irq_pend[idx]};
        else if (pin_hit) reg_rdata = {4'd0, regs_q.pin_mode[pin_sel], 2'b00};
        else              reg_rdata = 8'h00;
    end

    // R10
    flag_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_space |-> (reg_rdata[7:1] == 7'd0));
endmodule

// File: tb/irq_trigger_bank_test.sv
module irq_trigger_bank_test;
    localparam int NUM_SRC = 256;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] irq_in = '0;
    logic         reg_wen = 1'b0;
    logic [8:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic         ack_valid = 1'b0;
    logic [7:0]   ack_id = '0;
    logic [255:0] irq_pend;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    irq_trigger_bank uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wen(reg_wen),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_valid(ack_valid), .ack_id(ack_id), .irq_pend(irq_pend)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // fields: pin[13:10] mode[9:8] seq[7:4] exp[3:0], step 0 in the MSB
    localparam logic [13:0] VEC [8] = '{
        {4'd0, 2'd0, 4'b1101, 4'b1101},
        {4'd1, 2'd2, 4'b1010, 4'b1111},
        {4'd2, 2'd1, 4'b1000, 4'b0111},
        {4'd3, 2'd3, 4'b1111, 4'b1111},
        {4'd4, 2'd3, 4'b0011, 4'b0011},
        {4'd5, 2'd1, 4'b0111, 4'b0000},
        {4'd6, 2'd0, 4'b0100, 4'b0100},
        {4'd7, 2'd2, 4'b0001, 4'b0001}
    };

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack(input logic [7:0] id);
        @(negedge clk);
        ack_id = id; ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 flags clear at reset", irq_pend, '0);
        rd(9'h100, r);
        chk("R9 pin 0 resets to level", r, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12 latency on source 100 (reset default rising edge)
        irq_in[100] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R12 not visible after two edges", irq_pend[100], 1'b0);
        @(negedge clk);
        chk("R12 visible on third edge, R9 default rise", irq_pend[100], 1'b1);

        // R6 sticky after the line drops
        irq_in[100] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 edge flag sticky", irq_pend[100], 1'b1);

        // R7 non-zero write ignored, zero write clears
        wr(9'd100, 8'h01);
        rd(9'd100, r);
        chk("R7 non-zero write ignored", r, 8'h01);
        chk("R10 flag read upper bits zero", r[7:1], 7'd0);
        wr(9'd100, 8'h00);
        rd(9'd100, r);
        chk("R7 zero write clears edge flag", r, 8'h00);

        // R2 / R9: source 3 is level by mask
        irq_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 level flag follows input high", irq_pend[3], 1'b1);
        wr(9'd3, 8'h00);
        rd(9'd3, r);
        chk("R7 zero write ignored on level", r, 8'h01);
        ack(8'd3);
        chk("R8 ack ignored on level", irq_pend[3], 1'b1);
        irq_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 level flag drops with input", irq_pend[3], 1'b0);

        // R8 ack clears edge flag
        irq_in[100] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 rise sets source 100 again", irq_pend[100], 1'b1);
        ack(8'd100);
        chk("R8 ack clears edge flag", irq_pend[100], 1'b0);

        // R11 trigger and ack in the same cycle (source 101)
        irq_in[101] = 1'b1;
        @(negedge clk); @(negedge clk);
        ack_id = 8'd101; ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        chk("R11 trigger beats simultaneous clear", irq_pend[101], 1'b1);

        // R1 pin control field
        wr(9'h10F, 8'hFF);
        rd(9'h10F, r);
        chk("R1 pin mode readback only bits 3:2", r, 8'h0C);
        wr(9'h10F, 8'h08);
        rd(9'h10F, r);
        chk("R1 rise mode readback", r, 8'h08);
        rd(9'h1F0, r);
        chk("R10 unmapped address reads zero", r, 8'h00);

        // mode table: R2 R3 R4 R5 R6 through pin sources
        for (int v = 0; v < 8; v++) begin
            int src;
            src = 64 + int'(VEC[v][13:10]);
            irq_in[src] = 1'b0;
            repeat (4) @(negedge clk);
            wr(9'h100 + 9'(VEC[v][13:10]), {4'd0, VEC[v][9:8], 2'b00});
            wr(9'(src), 8'h00);
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                irq_in[src] = VEC[v][7-s];
                repeat (4) @(negedge clk);
                rd(9'(src), r);
                chk($sformatf("R2-mode table R3 R4 R5 R6 vec %0d step %0d", v, s),
                    r, {7'd0, VEC[v][3-s]});
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule